// File: doc/BRIEF.md
# Fractional M/N Clock-Rate Generator

This block turns one of several source tick streams into a slower tick stream whose average rate is a programmable fraction of the source rate. A selected source is first thinned by an integer pre-divider. An accumulator then keeps M of every N pre-divided ticks. The result drives a one-cycle rate enable output. A second output gives a level signal whose duty cycle is set by a D value when the dual-edge mode is selected.

Software programs the block through two 32-bit configuration words. The control word selects the source and sets the pre-divider, the counter mode, the counter enable and a hold bit. It also stores N in complemented difference form. The ratio word holds M and a complemented D value. The expected programming sequence is: set the hold bit, rewrite the ratio and control fields, then clear the hold bit. While the hold bit is set, the generator is kept in a clean starting state.

Top module: `mnd_frac_divider`

## Requirements
- R1: After a synchronous reset both configuration words read as zero internally, and `rate_en_o` and `div_lvl_o` are low.
- R2: The control word holds these fields: source select in bits [2:0], pre-divide-minus-one in bits [7:4], counter mode in bits [9:8], counter enable in bit 10, hold in bit 11, and the complement of (N−M) in bits [23:16]. The ratio word holds the complement of D in bits [7:0] and M in bits [23:16]. The block recovers N as ((~field) & 0xFF) + M and recovers D as (~field) & 0xFF.
- R3: The pre-divider emits one tick for every (pre field + 1) ticks of the selected source. A pre field of 0 passes every source tick through.
- R4: A source select value below the number of sources (4) picks that line of `src_tick_i`. Any larger value yields no ticks at all.
- R5: The M/N stage is active only when the counter enable bit is 1 and the mode field is nonzero. Otherwise every pre-divided tick produces an output pulse. This covers the all-zero programming used to turn fractional operation off.
- R6: When active, the accumulator adds M on each pre-divided tick. It emits a pulse and subtracts N when the sum reaches or exceeds N. Starting from a cleared state, N·k pre-divided ticks give exactly M·k pulses, including M = N and N near the top of the range.
- R7: While the hold bit is 1, the accumulator and the pre-divider count are cleared and both outputs are low. After release, counting restarts from zero.
- R8: In dual-edge mode (encoding 2), `div_lvl_o` is high when twice the accumulator value after the latest tick is below D, and it holds between ticks.
- R9: In every other case (mode 0, 1 or 3, or M/N inactive), `div_lvl_o` equals `rate_en_o`.
- R10: `rate_en_o` is registered. It is high in the cycle after the clock edge that samples a qualifying source tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr_i | input | 1 | Write strobe for the control word |
| ctl_wdata_i | input | 32 | Control word data |
| ratio_wr_i | input | 1 | Write strobe for the ratio word |
| ratio_wdata_i | input | 32 | Ratio word data |
| src_tick_i | input | 4 | One tick-enable line per source |
| rate_en_o | output | 1 | One-cycle output rate enable |
| div_lvl_o | output | 1 | Duty-shaped output level |

## Verification
The accumulator bound assumes that M and N change only while the hold bit is set. Under that condition the accumulator always starts from zero with a consistent ratio. Every scenario in the stimulus reprograms the block through the hold-set, rewrite, hold-clear sequence and never writes a ratio field while the generator is running. The enable-origin and level-tracking properties assume that the configuration is stable across each tick. The stimulus only drives source ticks after all writes are done.

// File: rtl/mnd_pkg.sv
package mnd_pkg;

  typedef enum logic [1:0] {
    MND_BYPASS   = 2'd0,
    MND_SINGLE   = 2'd1,
    MND_DUAL     = 2'd2,
    MND_SINGLE_B = 2'd3
  } mnd_mode_e;

  function automatic logic mode_uses_mn(input mnd_mode_e m);
    return m != MND_BYPASS;
  endfunction

endpackage

// File: rtl/mnd_cfg_regs.sv
module mnd_cfg_regs
  import mnd_pkg::*;
#(
  parameter int REG_W    = 32,
  parameter int CNT_W    = 8,
  parameter int PRE_W    = 4,
  parameter int SRC_W    = 3,
  parameter int SRC_LSB  = 0,
  parameter int PRE_LSB  = 4,
  parameter int MODE_LSB = 8,
  parameter int EN_BIT   = 10,
  parameter int HOLD_BIT = 11,
  parameter int NVAL_LSB = 16,
  parameter int MVAL_LSB = 16,
  parameter int DVAL_LSB = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [REG_W-1:0] ctl_wdata,
  input  logic             ratio_wr,
  input  logic [REG_W-1:0] ratio_wdata,
  output logic [SRC_W-1:0] src_sel,
  output logic [PRE_W-1:0] pre_val,
  output logic             hold,
  output logic             mn_active,
  output logic             dual_active,
  output logic [CNT_W-1:0] m_val,
  output logic [CNT_W:0]   n_val,
  output logic [CNT_W-1:0] d_val
);

  logic [REG_W-1:0] ctl_q;
  logic [REG_W-1:0] ratio_q;
  mnd_mode_e        mode;
  logic             cnt_en;
  logic [CNT_W-1:0] n_diff;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      ratio_q <= '0;
    end else begin
      if (ctl_wr)   ctl_q   <= ctl_wdata;
      if (ratio_wr) ratio_q <= ratio_wdata;
    end
  end

  always_comb begin
    src_sel     = ctl_q[SRC_LSB +: SRC_W];
    pre_val     = ctl_q[PRE_LSB +: PRE_W];
    mode        = mnd_mode_e'(ctl_q[MODE_LSB +: 2]);
    cnt_en      = ctl_q[EN_BIT];
    hold        = ctl_q[HOLD_BIT];
    m_val       = ratio_q[MVAL_LSB +: CNT_W];
    d_val       = ~ratio_q[DVAL_LSB +: CNT_W];
    n_diff      = ~ctl_q[NVAL_LSB +: CNT_W];
    n_val       = {1'b0, n_diff} + {1'b0, m_val};
    mn_active   = cnt_en && mode_uses_mn(mode);
    dual_active = mn_active && (mode == MND_DUAL);
  end

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{ctl_q, ratio_q};

endmodule

// File: rtl/mnd_src_prediv.sv
module mnd_src_prediv #(
  parameter int NUM_SRC = 4,
  parameter int SRC_W   = 3,
  parameter int PRE_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hold,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [SRC_W-1:0]   src_sel,
  input  logic [PRE_W-1:0]   pre_val,
  output logic               pre_tick
);

  logic [NUM_SRC-1:0] hit;
  logic               sel_tick;
  logic [PRE_W-1:0]   cnt_q;
  logic               at_limit;

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
    assign hit[gi] = src_tick[gi] && (src_sel == SRC_W'(gi));
  end

  assign sel_tick = |hit;
  assign at_limit = cnt_q >= pre_val;
  assign pre_tick = sel_tick && at_limit && !hold;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt_q <= '0;
    end else if (sel_tick) begin
      cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/mnd_mn_accum.sv
module mnd_mn_accum #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             mn_active,
  input  logic             dual_active,
  input  logic             tick,
  input  logic [CNT_W-1:0] m_val,
  input  logic [CNT_W:0]   n_val,
  input  logic [CNT_W-1:0] d_val,
  output logic [CNT_W:0]   acc_o,
  output logic             en_o,
  output logic             lvl_o
);

  localparam int SUM_W = CNT_W + 2;

  logic [CNT_W:0] acc_q;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] rem;
  logic             wrap;
  logic [CNT_W:0]   acc_nx;
  logic             lvl_nx;

  always_comb begin
    sum    = SUM_W'(acc_q) + SUM_W'(m_val);
    wrap   = sum >= SUM_W'(n_val);
    rem    = wrap ? (sum - SUM_W'(n_val)) : sum;
    acc_nx = rem[CNT_W:0];
    lvl_nx = (SUM_W'(acc_nx) << 1) < SUM_W'(d_val);
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      acc_q <= '0;
      en_o  <= 1'b0;
      lvl_o <= 1'b0;
    end else if (!mn_active) begin
      acc_q <= '0;
      en_o  <= tick;
      lvl_o <= tick;
    end else begin
      if (tick) acc_q <= acc_nx;
      en_o <= tick && wrap;
      if (dual_active) begin
        if (tick) lvl_o <= lvl_nx;
      end else begin
        lvl_o <= tick && wrap;
      end
    end
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/mnd_frac_divider.sv
module mnd_frac_divider #(
  parameter int REG_W    = 32,
  parameter int NUM_SRC  = 4,
  parameter int SRC_W    = 3,
  parameter int PRE_W    = 4,
  parameter int CNT_W    = 8,
  parameter int SRC_LSB  = 0,
  parameter int PRE_LSB  = 4,
  parameter int MODE_LSB = 8,
  parameter int EN_BIT   = 10,
  parameter int HOLD_BIT = 11,
  parameter int NVAL_LSB = 16,
  parameter int MVAL_LSB = 16,
  parameter int DVAL_LSB = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctl_wr_i,
  input  logic [REG_W-1:0]   ctl_wdata_i,
  input  logic               ratio_wr_i,
  input  logic [REG_W-1:0]   ratio_wdata_i,
  input  logic [NUM_SRC-1:0] src_tick_i,
  output logic               rate_en_o,
  output logic               div_lvl_o
);

  logic [SRC_W-1:0] src_sel;
  logic [PRE_W-1:0] pre_val;
  logic             hold;
  logic             mn_active;
  logic             dual_active;
  logic [CNT_W-1:0] m_val;
  logic [CNT_W:0]   n_val;
  logic [CNT_W-1:0] d_val;
  logic             pre_tick;
  logic [CNT_W:0]   acc;

  mnd_cfg_regs #(
    .REG_W(REG_W), .CNT_W(CNT_W), .PRE_W(PRE_W), .SRC_W(SRC_W),
    .SRC_LSB(SRC_LSB), .PRE_LSB(PRE_LSB), .MODE_LSB(MODE_LSB),
    .EN_BIT(EN_BIT), .HOLD_BIT(HOLD_BIT), .NVAL_LSB(NVAL_LSB),
    .MVAL_LSB(MVAL_LSB), .DVAL_LSB(DVAL_LSB)
  ) u_cfg (
    .clk(clk), .rst(rst),
    .ctl_wr(ctl_wr_i), .ctl_wdata(ctl_wdata_i),
    .ratio_wr(ratio_wr_i), .ratio_wdata(ratio_wdata_i),
    .src_sel(src_sel), .pre_val(pre_val), .hold(hold),
    .mn_active(mn_active), .dual_active(dual_active),
    .m_val(m_val), .n_val(n_val), .d_val(d_val)
  );

  mnd_src_prediv #(
    .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .PRE_W(PRE_W)
  ) u_pre (
    .clk(clk), .rst(rst), .hold(hold),
    .src_tick(src_tick_i), .src_sel(src_sel), .pre_val(pre_val),
    .pre_tick(pre_tick)
  );

  mnd_mn_accum #(
    .CNT_W(CNT_W)
  ) u_acc (
    .clk(clk), .rst(rst), .hold(hold),
    .mn_active(mn_active), .dual_active(dual_active),
    .tick(pre_tick), .m_val(m_val), .n_val(n_val), .d_val(d_val),
    .acc_o(acc), .en_o(rate_en_o), .lvl_o(div_lvl_o)
  );

endmodule

// File: rtl/mnd_frac_divider_chk.sv
module mnd_frac_divider_chk #(
  parameter int NUM_SRC = 4,
  parameter int SRC_W   = 3,
  parameter int CNT_W   = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             hold,
  input logic             mn_active,
  input logic             dual_active,
  input logic             pre_tick,
  input logic [SRC_W-1:0] src_sel,
  input logic [CNT_W:0]   acc,
  input logic [CNT_W:0]   n_val,
  input logic             rate_en,
  input logic             div_lvl
);

  localparam logic [SRC_W:0] SRC_LIMIT = (SRC_W+1)'(NUM_SRC);

  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, src_sel} >= SRC_LIMIT) |-> !pre_tick); // R4

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
    (!mn_active && pre_tick) |=> rate_en); // R5

  AST_ACC_BELOW_N: assert property (@(posedge clk) disable iff (rst)
    (mn_active && n_val != '0) |-> (acc < n_val)); // R6

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    hold |=> (!rate_en && !div_lvl)); // R7

  AST_LVL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !dual_active |=> (div_lvl == rate_en)); // R9

  AST_EN_FROM_TICK: assert property (@(posedge clk) disable iff (rst)
    rate_en |-> $past(pre_tick)); // R10

endmodule

bind mnd_frac_divider mnd_frac_divider_chk #(
  .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .hold(hold), .mn_active(mn_active),
  .dual_active(dual_active), .pre_tick(pre_tick), .src_sel(src_sel),
  .acc(acc), .n_val(n_val), .rate_en(rate_en_o), .div_lvl(div_lvl_o)
);

// File: tb/mnd_frac_divider_tb.sv
module mnd_frac_divider_tb;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic        ratio_wr = 1'b0;
  logic [31:0] ratio_wdata = '0;
  logic [3:0]  src_tick = '0;
  logic        rate_en;
  logic        div_lvl;

  int total = 0;
  int bad = 0;
  logic [31:0] ctl_shadow = '0;

  always #4 clk = ~clk;

  mnd_frac_divider u_dut (
    .clk(clk), .rst(rst),
    .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata),
    .ratio_wr_i(ratio_wr), .ratio_wdata_i(ratio_wdata),
    .src_tick_i(src_tick),
    .rate_en_o(rate_en), .div_lvl_o(div_lvl)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [31:0] d);
    ctl_wr = 1'b1; ctl_wdata = d; ctl_shadow = d;
    @(posedge clk); #1;
    ctl_wr = 1'b0;
  endtask

  task automatic wr_ratio(input logic [31:0] d);
    ratio_wr = 1'b1; ratio_wdata = d;
    @(posedge clk); #1;
    ratio_wr = 1'b0;
  endtask

  // Software sequence: hold, rewrite ratio and control, release (R2 layout)
  task automatic prog(input int m, input int n, input int pre, input int src,
                      input int mode, input bit en);
    logic [31:0] w;
    logic [7:0]  nf;
    logic [7:0]  df;
    wr_ctl(32'h0000_0800);
    df = (n != 0) ? ~8'(n) : 8'h00;
    wr_ratio((n != 0) ? ({8'h00, 8'(m), 8'h00, df}) : 32'h0);
    nf = (n != 0) ? ~8'(n - m) : 8'h00;
    w = {8'h00, nf, 4'h0, 1'b1, en, 2'(mode), 4'(pre), 1'b0, 3'(src)};
    wr_ctl(w);
    wr_ctl(w & ~32'h0000_0800);
  endtask

  task automatic run_ticks(input logic [3:0] every, input logic [3:0] odd_only,
                           input int cycles, output int pulses, output int highs);
    pulses = 0; highs = 0;
    for (int i = 0; i < cycles; i++) begin
      src_tick = every | (((i % 2) == 1) ? odd_only : 4'h0);
      @(posedge clk); #1;
      if (rate_en) pulses++;
      if (div_lvl) highs++;
    end
    src_tick = '0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      if (rate_en) pulses++;
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1; rst = 1'b0;
    chk("R1 rate_en after reset", int'(rate_en), 0);
    chk("R1 div_lvl after reset", int'(div_lvl), 0);
  endtask

  task automatic t_latency;
    prog(0, 0, 0, 0, 0, 1'b0);
    src_tick = 4'b0001;
    @(posedge clk); #1;
    chk("R10 pulse one cycle after tick", int'(rate_en), 1);
    src_tick = '0;
    @(posedge clk); #1;
    chk("R10 pulse ends", int'(rate_en), 0);
  endtask

  task automatic t_prediv;
    int p, h;
    prog(0, 0, 2, 0, 0, 1'b0);
    run_ticks(4'b0001, 4'b0000, 30, p, h);
    chk("R3 R5 divide by 3 bypass", p, 10);
    prog(0, 0, 0, 0, 0, 1'b0);
    run_ticks(4'b0001, 4'b0000, 12, p, h);
    chk("R3 pre 0 pass-through", p, 12);
    chk("R9 bypass level equals pulse", h, 12);
  endtask

  task automatic t_srcsel;
    int p, h;
    prog(0, 0, 0, 1, 0, 1'b0);
    run_ticks(4'b0010, 4'b0100, 10, p, h);
    chk("R4 select line 1", p, 10);
    prog(0, 0, 0, 2, 0, 1'b0);
    run_ticks(4'b0010, 4'b0100, 10, p, h);
    chk("R4 select line 2", p, 5);
    prog(0, 0, 0, 5, 0, 1'b0);
    run_ticks(4'b1111, 4'b0000, 10, p, h);
    chk("R4 out of range select", p, 0);
  endtask

  task automatic t_mn;
    int p, h;
    prog(3, 8, 0, 0, 2, 1'b1);
    run_ticks(4'b0001, 4'b0000, 40, p, h);
    chk("R2 R6 M3 N8 k5", p, 15);
    prog(2, 5, 1, 0, 2, 1'b1);
    run_ticks(4'b0001, 4'b0000, 30, p, h);
    chk("R3 R6 M2 N5 with divide by 2", p, 6);
    prog(4, 4, 0, 0, 2, 1'b1);
    run_ticks(4'b0001, 4'b0000, 8, p, h);
    chk("R6 M equals N", p, 8);
    prog(1, 200, 0, 0, 2, 1'b1);
    run_ticks(4'b0001, 4'b0000, 400, p, h);
    chk("R2 R6 large N 200", p, 2);
  endtask

  task automatic t_modes;
    int p, h;
    prog(1, 4, 0, 0, 2, 1'b1);
    run_ticks(4'b0001, 4'b0000, 16, p, h);
    chk("R8 dual duty high cycles", h, 8);
    prog(1, 3, 0, 0, 1, 1'b1);
    run_ticks(4'b0001, 4'b0000, 12, p, h);
    chk("R6 single mode pulses", p, 4);
    chk("R9 single mode level", h, 4);
    prog(1, 3, 0, 0, 3, 1'b1);
    run_ticks(4'b0001, 4'b0000, 12, p, h);
    chk("R9 mode 3 level", h, 4);
    prog(1, 3, 0, 0, 2, 1'b0);
    run_ticks(4'b0001, 4'b0000, 10, p, h);
    chk("R5 enable bit clear", p, 10);
    prog(1, 3, 0, 0, 0, 1'b1);
    run_ticks(4'b0001, 4'b0000, 10, p, h);
    chk("R5 mode 0 with enable", p, 10);
  endtask

  task automatic t_hold;
    int p, h;
    prog(1, 4, 0, 0, 2, 1'b1);
    wr_ctl(ctl_shadow | 32'h0000_0800);
    run_ticks(4'b0001, 4'b0000, 10, p, h);
    chk("R7 no pulses in hold", p, 0);
    chk("R7 level low in hold", h, 0);
    wr_ctl(ctl_shadow & ~32'h0000_0800);
    run_ticks(4'b0001, 4'b0000, 3, p, h);
    chk("R7 three ticks before hold", p, 0);
    wr_ctl(ctl_shadow | 32'h0000_0800);
    wr_ctl(ctl_shadow & ~32'h0000_0800);
    run_ticks(4'b0001, 4'b0000, 3, p, h);
    chk("R7 accumulator restarted", p, 0);
    run_ticks(4'b0001, 4'b0000, 1, p, h);
    chk("R7 fourth tick pulses", p, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_prediv();
    t_srcsel();
    t_mn();
    t_modes();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule